// File: doc/BRIEF.md
# DMA Channel Control Registers

This block holds the control and progress registers of one bus-master DMA channel in a SCSI host adapter. Software programs a start count, a start address and a start descriptor address, then issues a command. A 2-bit command field selects one of four operations: idle turns the channel off, blast is accepted and does nothing, abort sends a one-cycle request to the SCSI side, and start copies the start values into the working registers, clears the status and enables the channel.

The data mover offers each transfer chunk with its direction and length. The block trims the chunk to the remaining byte count and returns the granted length and the current working address. When the chunk is granted, the count goes down and the address goes up by the granted amount. A chunk whose direction does not match the command's direction bit is refused. A command-complete pulse forces the remaining count to zero and sets the done flag. Status flags are cleared in one of two ways, picked by a mode input: writing ones clears the matching flags, or reading the status register clears them.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, reading each index returns: command 0, start count 0, start address 0, working count 0, working address 0xFFFFFFFF, status 0, start descriptor 0, working descriptor 0xFFFFFFFD. dma_en_o and abort_o are 0.
- R2: The register index map is 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor, 7 working descriptor. Indices 1, 2 and 6 store the full 32-bit written value and read it back.
- R3: Writes to indices 3, 4 and 7 leave those registers unchanged.
- R4: A command write with bits [1:0]=3 (start) copies start count to working count, start address to working address and start descriptor to working descriptor. It also clears all six status bits, and dma_en_o is 1 from the next clock edge.
- R5: A command write with bits [1:0]=0 (idle) drives dma_en_o to 0 from the next edge. Bits [1:0]=1 (blast) leaves dma_en_o and all counters unchanged.
- R6: A command write with bits [1:0]=2 (abort) raises abort_o for exactly the one cycle after the write edge and leaves dma_en_o unchanged. abort_o is 0 at every other time.
- R7: The command register stores and returns the whole 32-bit written value. Bit 7 is the direction, where 1 means device-to-memory.
- R8: While xfer_vld_i is high with a matching direction, xfer_len_o is the smaller of xfer_len_i and the working count, and xfer_adr_o is the working address. At the edge, the working count drops by xfer_len_o and the working address rises by xfer_len_o.
- R9: A chunk whose xfer_to_mem_i differs from command bit 7 gives xfer_len_o=0 and leaves the working count and address unchanged.
- R10: A cmd_done_i pulse sets the working count to 0 and sets status bit 3 (done).
- R11: With stat_rdclr_i=0, writing the status register clears each of bits 1 (error), 2 (abort) and 3 (done) whose written bit is 1. The other status bits are unaffected.
- R12: With stat_rdclr_i=1, status writes are ignored. A status read returns the current flags, and bits 1 to 3 are cleared at the edge that ends the read.
- R13: A status read returns bit 4 as 1 whenever core_irq_i is 1, in addition to the stored bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_idx_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_idx_i, same cycle |
| stat_rdclr_i | input | 1 | 1 selects clear-on-read status, 0 selects write-one-to-clear |
| core_irq_i | input | 1 | SCSI core interrupt flag |
| xfer_vld_i | input | 1 | Data mover offers a chunk |
| xfer_to_mem_i | input | 1 | Chunk direction, 1 = device to memory |
| xfer_len_i | input | 32 | Requested chunk length in bytes |
| xfer_len_o | output | 32 | Granted chunk length |
| xfer_adr_o | output | 32 | Working address for the chunk |
| cmd_done_i | input | 1 | Command-complete pulse |
| dma_en_o | output | 1 | DMA enable level to the SCSI core |
| abort_o | output | 1 | One-cycle abort request |

## Verification
The hardest state to reach from the ports is a status flag being cleared by a read in clear-on-read mode. Only command-complete can set a flag, so the stimulus first drives a done pulse, then reads the status register with the mode input high. It then reads again to see the flag gone, and writes the register to confirm the write is ignored. Clamping is reached by loading small start counts and offering random chunk lengths that often exceed the remaining count. This mixes granted, clamped and wrong-direction chunks with random register writes, commands and mode changes.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned SW = 6;

  typedef enum logic [2:0] {
    IDX_CMD = 3'd0, IDX_SCNT = 3'd1, IDX_SADR = 3'd2, IDX_WCNT = 3'd3,
    IDX_WADR = 3'd4, IDX_STAT = 3'd5, IDX_SDSC = 3'd6, IDX_WDSC = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0, OP_BLAST = 2'd1, OP_ABORT = 2'd2, OP_START = 2'd3
  } cmd_op_e;

  localparam int unsigned CMD_DIR_BIT = 7;
  localparam int unsigned ST_DONE     = 3;
  localparam int unsigned ST_IRQ      = 4;
  localparam logic [SW-1:0] ST_CLR_MASK = 6'b001110;
endpackage

// File: rtl/dma_cmd_ctl.sv
module dma_cmd_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cmd_o,
  output logic         start_o,
  output logic         dma_en_o,
  output logic         abort_o
);
  cmd_op_e op;
  assign op      = cmd_op_e'(wdata_i[1:0]);
  assign start_o = wr_i && (op == OP_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o    <= '0;
      dma_en_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      abort_o <= wr_i && (op == OP_ABORT);
      if (wr_i) begin
        cmd_o <= wdata_i;
        if (op == OP_IDLE)       dma_en_o <= 1'b0;
        else if (op == OP_START) dma_en_o <= 1'b1;
      end
    end
  end

  assert_start_enables_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op == OP_START) |=> dma_en_o);
  assert_idle_disables_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op == OP_IDLE) |=> !dma_en_o);
  assert_abort_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op == OP_ABORT) |=> (abort_o && $stable(dma_en_o)));
  assert_no_spurious_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !abort_o);
endmodule

// File: rtl/dma_work_ctr.sv
module dma_work_ctr
  import dma_chan_pkg::*;
#(
  parameter int unsigned    W        = DW,
  parameter logic [W-1:0]   WADR_RST = '1,
  parameter logic [W-1:0]   WDSC_RST = {{(W-2){1'b1}}, 2'b01}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] scnt_i,
  input  logic [W-1:0] sadr_i,
  input  logic [W-1:0] sdsc_i,
  input  logic         take_i,
  input  logic [W-1:0] len_i,
  input  logic         done_i,
  output logic [W-1:0] grant_o,
  output logic [W-1:0] wcnt_o,
  output logic [W-1:0] wadr_o,
  output logic [W-1:0] wdsc_o
);
  assign grant_o = (len_i < wcnt_o) ? len_i : wcnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_o <= '0;
      wadr_o <= WADR_RST;
      wdsc_o <= WDSC_RST;
    end else if (load_i) begin
      wcnt_o <= scnt_i;
      wadr_o <= sadr_i;
      wdsc_o <= sdsc_i;
    end else begin
      if (done_i)      wcnt_o <= '0;
      else if (take_i) wcnt_o <= wcnt_o - grant_o;
      if (take_i)      wadr_o <= wadr_o + grant_o;
    end
  end

  assert_cnt_no_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (wcnt_o <= $past(wcnt_o)));
  assert_done_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !load_i) |=> (wcnt_o == '0));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !take_i && !done_i) |=> ($stable(wcnt_o) && $stable(wadr_o)));
endmodule

// File: rtl/dma_status.sv
module dma_status
  import dma_chan_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_all_i,
  input  logic          done_i,
  input  logic          rdclr_mode_i,
  input  logic          wr_i,
  input  logic [SW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [SW-1:0] stat_o
);
  logic [SW-1:0] stat_d;

  always_comb begin
    stat_d = stat_o;
    if (wr_i && !rdclr_mode_i) stat_d = stat_d & ~(wdata_i & ST_CLR_MASK);
    if (rd_i && rdclr_mode_i)  stat_d = stat_d & ~ST_CLR_MASK;
    if (clr_all_i)             stat_d = '0;
    if (done_i)                stat_d[ST_DONE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= stat_d;
  end

  assert_done_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_o[ST_DONE]);
  assert_read_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rdclr_mode_i && !done_i) |=> (stat_o[3:1] == 3'b000));
  assert_mode_blocks_wr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdclr_mode_i && !rd_i && !done_i && !clr_all_i) |=> $stable(stat_o));
  assert_start_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && !done_i) |=> (stat_o == '0));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [2:0]    reg_idx_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          stat_rdclr_i,
  input  logic          core_irq_i,
  input  logic          xfer_vld_i,
  input  logic          xfer_to_mem_i,
  input  logic [DW-1:0] xfer_len_i,
  output logic [DW-1:0] xfer_len_o,
  output logic [DW-1:0] xfer_adr_o,
  input  logic          cmd_done_i,
  output logic          dma_en_o,
  output logic          abort_o
);
  localparam logic [DW-1:0] WADR_RST = '1;
  localparam logic [DW-1:0] WDSC_RST = {{(DW-2){1'b1}}, 2'b01};

  reg_idx_e      idx;
  logic [DW-1:0] cmd_q, scnt_q, sadr_q, sdsc_q;
  logic [DW-1:0] wcnt, wadr, wdsc, grant;
  logic [SW-1:0] stat;
  logic          start, take;

  assign idx = reg_idx_e'(reg_idx_i);

  dma_cmd_ctl #(.W(DW)) u_cmd (
    .clk_i, .rst_ni,
    .wr_i     (reg_wr_i && idx == IDX_CMD),
    .wdata_i  (reg_wdata_i),
    .cmd_o    (cmd_q),
    .start_o  (start),
    .dma_en_o (dma_en_o),
    .abort_o  (abort_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scnt_q <= '0;
      sadr_q <= '0;
      sdsc_q <= '0;
    end else if (reg_wr_i) begin
      if (idx == IDX_SCNT) scnt_q <= reg_wdata_i;
      if (idx == IDX_SADR) sadr_q <= reg_wdata_i;
      if (idx == IDX_SDSC) sdsc_q <= reg_wdata_i;
    end
  end

  assign take = xfer_vld_i && (xfer_to_mem_i == cmd_q[CMD_DIR_BIT]);

  dma_work_ctr #(.W(DW), .WADR_RST(WADR_RST), .WDSC_RST(WDSC_RST)) u_ctr (
    .clk_i, .rst_ni,
    .load_i  (start),
    .scnt_i  (scnt_q),
    .sadr_i  (sadr_q),
    .sdsc_i  (sdsc_q),
    .take_i  (take),
    .len_i   (xfer_len_i),
    .done_i  (cmd_done_i),
    .grant_o (grant),
    .wcnt_o  (wcnt),
    .wadr_o  (wadr),
    .wdsc_o  (wdsc)
  );

  assign xfer_len_o = take ? grant : '0;
  assign xfer_adr_o = wadr;

  dma_status u_stat (
    .clk_i, .rst_ni,
    .clr_all_i    (start),
    .done_i       (cmd_done_i),
    .rdclr_mode_i (stat_rdclr_i),
    .wr_i         (reg_wr_i && idx == IDX_STAT),
    .wdata_i      (reg_wdata_i[SW-1:0]),
    .rd_i         (reg_rd_i && idx == IDX_STAT),
    .stat_o       (stat)
  );

  always_comb begin
    unique case (idx)
      IDX_CMD:  reg_rdata_o = cmd_q;
      IDX_SCNT: reg_rdata_o = scnt_q;
      IDX_SADR: reg_rdata_o = sadr_q;
      IDX_WCNT: reg_rdata_o = wcnt;
      IDX_WADR: reg_rdata_o = wadr;
      IDX_STAT: reg_rdata_o = {{(DW-SW){1'b0}}, stat | (SW'(core_irq_i) << ST_IRQ)};
      IDX_SDSC: reg_rdata_o = sdsc_q;
      default:  reg_rdata_o = wdsc;
    endcase
  end

  assert_wrong_dir_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_vld_i && xfer_to_mem_i != cmd_q[CMD_DIR_BIT]) |-> (xfer_len_o == '0));
  assert_grant_clamped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_len_o <= wcnt) && (xfer_len_o <= xfer_len_i));
  assert_irq_visible_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_irq_i && idx == IDX_STAT) |-> reg_rdata_o[ST_IRQ]);
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        rdclr = 1'b0, irq = 1'b0;
  logic        xvld = 1'b0, xtomem = 1'b0;
  logic [31:0] xlen = '0, xlen_o, xadr_o;
  logic        done = 1'b0, dma_en, abort;

  int checks = 0, errors = 0;

  logic [31:0] m_cmd, m_scnt, m_sadr, m_wcnt, m_wadr, m_sdsc, m_wdsc;
  logic [5:0]  m_st;
  logic        m_en;

  always #10 clk = ~clk;

  dma_chan_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .stat_rdclr_i(rdclr), .core_irq_i(irq), .xfer_vld_i(xvld),
    .xfer_to_mem_i(xtomem), .xfer_len_i(xlen), .xfer_len_o(xlen_o),
    .xfer_adr_o(xadr_o), .cmd_done_i(done), .dma_en_o(dma_en), .abort_o(abort)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [2:0] i, input logic irq_v);
    case (i)
      3'd0: return m_cmd;
      3'd1: return m_scnt;
      3'd2: return m_sadr;
      3'd3: return m_wcnt;
      3'd4: return m_wadr;
      3'd5: return {26'd0, m_st | {1'b0, irq_v, 4'b0}};
      3'd6: return m_sdsc;
      default: return m_wdsc;
    endcase
  endfunction

  function automatic logic [31:0] min32(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_reset();
    m_cmd = 0; m_scnt = 0; m_sadr = 0; m_wcnt = 0; m_wadr = 32'hFFFF_FFFF;
    m_sdsc = 0; m_wdsc = 32'hFFFF_FFFD; m_st = 0; m_en = 0;
  endtask

  task automatic do_wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (i)
      3'd0: begin
        m_cmd = d;
        if (d[1:0] == 2'd0) m_en = 1'b0;
        if (d[1:0] == 2'd3) begin
          m_en = 1'b1; m_wcnt = m_scnt; m_wadr = m_sadr; m_wdsc = m_sdsc; m_st = 0;
        end
      end
      3'd1: m_scnt = d;
      3'd2: m_sadr = d;
      3'd6: m_sdsc = d;
      3'd5: if (!rdclr) m_st = m_st & ~(d[5:0] & 6'b001110);
      default: ;
    endcase
    chk("R6 abort pulse", {31'd0, abort}, {31'd0, (i == 3'd0 && d[1:0] == 2'd2)});
    chk("R5 dma_en level", {31'd0, dma_en}, {31'd0, m_en});
  endtask

  task automatic do_rd(input string tag, input logic [2:0] i);
    @(negedge clk);
    reg_rd = 1'b1; reg_idx = i;
    #2 chk(tag, reg_rdata, exp_read(i, irq));
    @(negedge clk);
    reg_rd = 1'b0;
    if (i == 3'd5 && rdclr) m_st = m_st & ~6'b001110;
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 8; i++) do_rd(tag, 3'(i));
  endtask

  task automatic do_xfer(input logic to_mem, input logic [31:0] len);
    logic        ok;
    logic [31:0] g;
    @(negedge clk);
    xvld = 1'b1; xtomem = to_mem; xlen = len;
    ok = (to_mem == m_cmd[7]);
    g  = ok ? min32(len, m_wcnt) : 32'd0;
    #2;
    chk(ok ? "R8 grant" : "R9 refused", xlen_o, g);
    chk("R8 address out", xadr_o, m_wadr);
    @(negedge clk);
    xvld = 1'b0;
    if (ok) begin m_wcnt = m_wcnt - g; m_wadr = m_wadr + g; end
  endtask

  task automatic do_done();
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    m_wcnt = 0; m_st[3] = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 dma_en", {31'd0, dma_en}, 32'd0);
    chk("R1 abort", {31'd0, abort}, 32'd0);
    check_all("R1 reset value");
    // R2 plain registers, R3 working registers ignore writes
    do_wr(3'd1, 32'd100); do_wr(3'd2, 32'h1000_0000); do_wr(3'd6, 32'hCAFE_0010);
    check_all("R2 readback");
    do_wr(3'd3, 32'h5555_5555); do_wr(3'd4, 32'h1234_5678); do_wr(3'd7, 32'h0);
    check_all("R3 ignored write");
    // R4 start, device-to-memory; R7 full command readback
    do_wr(3'd0, 32'hA5A5_00F3);
    check_all("R4 R7 start load");
    // R8 chunk within count, then clamped
    do_xfer(1'b1, 32'd40);
    do_xfer(1'b1, 32'd500);
    do_rd("R8 count exhausted", 3'd3);
    do_rd("R8 address advanced", 3'd4);
    // R9 wrong direction
    do_wr(3'd0, 32'h0000_0083);
    do_xfer(1'b0, 32'd10);
    do_rd("R9 count held", 3'd3);
    // R10 completion
    do_xfer(1'b1, 32'd7);
    do_done();
    do_rd("R10 count zero", 3'd3);
    do_rd("R10 done flag", 3'd5);
    // R11 write-one-to-clear
    rdclr = 1'b0;
    do_wr(3'd5, 32'h0000_0030);
    do_rd("R11 unmasked bits keep done", 3'd5);
    do_wr(3'd5, 32'h0000_0008);
    do_rd("R11 done cleared", 3'd5);
    // R12 clear-on-read
    do_done();
    rdclr = 1'b1;
    do_wr(3'd5, 32'h0000_003F);
    do_rd("R12 write ignored, read returns done", 3'd5);
    do_rd("R12 cleared after read", 3'd5);
    // R13 SCSI interrupt merged into status
    irq = 1'b1;
    do_rd("R13 irq bit", 3'd5);
    irq = 1'b0;
    do_rd("R13 irq bit gone", 3'd5);
    // R6 abort keeps enable, R5 blast no effect, idle disables
    do_wr(3'd0, 32'h0000_0082);
    do_wr(3'd0, 32'h0000_0081);
    check_all("R5 blast no change");
    do_wr(3'd0, 32'h0000_0080);
    // random phase
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom % 8;
      rdclr = 1'($urandom);
      irq   = 1'($urandom);
      case (op)
        0: do_wr(3'($urandom), $urandom);
        1: do_wr(3'd1, $urandom % 200);
        2: do_wr(3'd0, {$urandom, 2'b00} | 32'(($urandom % 4)));
        3, 4: do_xfer(1'($urandom), $urandom % 64);
        5: do_done();
        6: do_wr(3'd5, $urandom);
        default: do_rd("R12 R13 random read", 3'($urandom));
      endcase
    end
    check_all("R8 random final");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule